// File: doc/BRIEF.md
# Rewindable Parity-Width FIFO Buffer

This block is a clocked first-in first-out store that holds 512 words of 9 bits. The ninth bit lets a parity bit travel with each byte. A producer presents single-cycle write strobes and a consumer presents single-cycle read strobes. The block keeps a write pointer and a read pointer, and from their difference it derives an empty flag, a full flag and a half-full flag. A write that arrives while the store is full is dropped. A read that arrives while the store is empty is dropped.

A rewind strobe sends only the read pointer back to the first location and leaves the write pointer alone. The consumer can then replay everything written since reset, for example after a receiver reports an error. The flags are re-derived from the new distance between the pointers.

Read data appears on a registered output port together with a valid qualifier. While no read is delivering data, that port is held at zero, which stands in for a released bus. A synchronous reset clears both pointers and all flags.

Top module: `rewind_fifo`

## Requirements
- R1: While reset is high at a clock edge, both pointers return to location zero. After that edge empty reads 1, full reads 0, half_full reads 0 and rd_valid reads 0.
- R2: Words leave in the order they were accepted. The word for an accepted read appears on rd_data, with rd_valid high, in the cycle after the read's clock edge.
- R3: empty is 1 exactly when the occupancy (write pointer minus read pointer) is zero. A read strobe while empty is ignored: the read pointer holds and no data is delivered.
- R4: full is 1 exactly when the occupancy equals the depth (512). A write strobe while full is ignored: the write pointer holds and the offered word is never delivered.
- R5: half_full becomes 1 after the accepted write that lifts the occupancy above half the depth (from 256 to 257).
- R6: half_full becomes 0 after the accepted read that brings the occupancy to half the depth or less (from 257 to 256).
- R7: A rewind strobe sets the read pointer to zero and leaves the write pointer unchanged. Read and write strobes in that cycle are ignored. Later reads replay the stored words from the first one written after reset. This is guaranteed only while no more than 512 writes have been accepted since reset.
- R8: After a rewind, empty, full and half_full follow the new occupancy, which equals the count of writes accepted since reset.
- R9: In any cycle that does not follow an accepted read, rd_valid is 0 and rd_data is all zeros.
- R10: A read and a write in the same cycle on an empty store accept only the write. A read and a write in the same cycle on a full store accept only the read. Acceptance is decided from the flags before the edge.
- R11: A read and a write in the same cycle, when the store is neither empty nor full, are both accepted and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_req | input | 1 | Single-cycle write strobe |
| wr_data | input | 9 | Word to store |
| rd_req | input | 1 | Single-cycle read strobe |
| rewind | input | 1 | Single-cycle strobe that returns the read pointer to zero |
| rd_data | output | 9 | Word delivered by a read; zero when rd_valid is low |
| rd_valid | output | 1 | High in the cycle after an accepted read |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals the depth |
| half_full | output | 1 | Occupancy is above half the depth |

## Verification
A pointer that slips by one place shows up at once as the wrong word in the rd_data cycle of the next read. It also moves the empty and full flag transitions one strobe too early or too late. A lost write or a missed boundary block makes the delivered stream drift against the expected order, and the stream is compared word by word. A rewind that also disturbs the write pointer is caught by the flags in the cycle after the rewind and again during the replayed stream. Half-full placement is checked exactly at the 256 and 257 occupancy boundaries, in both directions.

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_req,
  input  logic             rewind,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty,
  output logic             full,
  output logic             half_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW-1:0] occ, occ_nxt;
  logic wr_go, rd_go;

  assign occ   = wp - rp;
  assign empty = (occ == '0);
  assign full  = (occ == FULL_CNT);

  // acceptance is decided on the flags before the edge; rewind wins
  assign wr_go = wr_req & ~full  & ~rewind;
  assign rd_go = rd_req & ~empty & ~rewind;

  assign occ_nxt = occ + PW'(wr_go) - PW'(rd_go);

  always_ff @(posedge clk) begin
    if (wr_go) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_go) wp <= wp + 1'b1;
      if (rewind) rp <= '0;
      else if (rd_go) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_go;
      rd_data  <= rd_go ? mem[rp[AW-1:0]] : '0;
    end
  end

  // set by a write crossing upward, cleared by a read crossing downward
  always_ff @(posedge clk) begin
    if (rst)
      half_full <= 1'b0;
    else if (rewind)
      half_full <= (wp > HALF_CNT);
    else if (wr_go && !rd_go && occ_nxt > HALF_CNT)
      half_full <= 1'b1;
    else if (rd_go && !wr_go && occ_nxt <= HALF_CNT)
      half_full <= 1'b0;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (empty && !full && !half_full && !rd_valid));

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(empty && full));

  p_empty_holds_rp_r3: assert property (@(posedge clk) disable iff (rst)
    (empty && !rewind) |=> $stable(rp));

  p_full_holds_wp_r4: assert property (@(posedge clk) disable iff (rst)
    full |=> $stable(wp));

  p_half_set_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !rd_req && !rewind && occ == HALF_CNT) |=> half_full);

  p_half_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !wr_req && !rewind && occ == HALF_CNT + 1'b1) |=> !half_full);

  p_rewind_ptrs_r7: assert property (@(posedge clk) disable iff (rst)
    rewind |=> (rp == '0 && $stable(wp)));

  p_idle_output_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

endmodule

// File: tb/rewind_fifo_tb_top.sv
module rewind_fifo_tb_top;
  localparam int W = 9;
  localparam int D = 512;

  logic clk = 1'b0;
  logic rst, wr_req, rd_req, rewind;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic rd_valid, empty, full, half_full;

  always #2 clk = ~clk;

  rewind_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data),
    .rd_req(rd_req), .rewind(rewind), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty(empty), .full(full), .half_full(half_full)
  );

  int n_chk = 0;
  int n_bad = 0;
  int wp_m = 0;
  int rp_m = 0;
  bit pend_valid = 0;
  bit in_reset = 1;
  bit done = 0;
  logic [W-1:0] mdl_mem [D];
  logic [W-1:0] exp_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_flags(input string req);
    int occ;
    occ = wp_m - rp_m;
    check(empty == (occ == 0), {req, " empty"}, int'(empty), int'(occ == 0));
    check(full == (occ == D), {req, " full"}, int'(full), int'(occ == D));
    check(half_full == (occ > D / 2), {req, " half_full"}, int'(half_full), int'(occ > D / 2));
  endtask

  task automatic step(input bit w, input logic [W-1:0] d, input bit r, input bit rt);
    int occ;
    bit wa, ra;
    @(negedge clk);
    wr_req = w; wr_data = d; rd_req = r; rewind = rt;
    occ = wp_m - rp_m;
    wa = w && occ != D && !rt;
    ra = r && occ != 0 && !rt;
    @(posedge clk);
    #1;
    if (ra) begin exp_q.push_back(mdl_mem[rp_m % D]); rp_m++; end
    if (wa) begin mdl_mem[wp_m % D] = d; wp_m++; end
    if (rt) rp_m = 0;
    pend_valid = ra;
    wr_req = 0; rd_req = 0; rewind = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_reset = 1; wr_req = 0; rd_req = 0; rewind = 0;
    repeat (2) @(posedge clk);
    #1;
    wp_m = 0; rp_m = 0; pend_valid = 0;
    check(exp_q.size() == 0, "R2 stream drained before reset", exp_q.size(), 0);
    exp_q.delete();
    @(negedge clk);
    rst = 0; in_reset = 0;
    chk_flags("R1");
    check(rd_valid == 0, "R1 rd_valid", int'(rd_valid), 0);
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 37 + 11) ^ (i >> 3));
  endfunction

  // monitor: compares delivered words against the scoreboard queue
  always @(negedge clk) begin
    if (!in_reset) begin
      check(rd_valid == pend_valid, "R9 rd_valid", int'(rd_valid), int'(pend_valid));
      if (rd_valid) begin
        if (exp_q.size() == 0)
          check(0, "R2 unexpected word", int'(rd_data), -1);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R2 word order", int'(rd_data), int'(e));
        end
      end else
        check(rd_data == '0, "R9 idle rd_data", int'(rd_data), 0);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_req = 0; rd_req = 0; rewind = 0; wr_data = '0;
    do_reset();

    // R3: read on empty is ignored
    step(0, '0, 1, 0);
    chk_flags("R3 read on empty");
    // R10: read and write together while empty
    step(1, 9'h1A5, 1, 0);
    chk_flags("R10 empty r+w");
    for (int i = 0; i < 6; i++) step(1, pat(i), 0, 0);
    chk_flags("R2 after writes");
    // R11: concurrent read and write in the middle
    for (int i = 6; i < 12; i++) begin
      step(1, pat(i), 1, 0);
      chk_flags("R11 concurrent");
    end
    for (int i = 0; i < 8; i++) step(0, '0, 1, 0);
    step(0, '0, 0, 0);
    chk_flags("R3 drained");
    step(0, '0, 1, 0);
    chk_flags("R3 read after drain");
    step(0, '0, 0, 0);

    // R5 / R6 at the half boundary
    do_reset();
    for (int i = 0; i < D / 2; i++) step(1, pat(i + 100), 0, 0);
    chk_flags("R5 at half");
    step(1, pat(999), 0, 0);
    chk_flags("R5 above half");
    check(half_full == 1, "R5 set", int'(half_full), 1);
    step(0, '0, 1, 0);
    chk_flags("R6 back to half");
    check(half_full == 0, "R6 clear", int'(half_full), 0);
    step(1, pat(5), 0, 0);
    check(half_full == 1, "R5 set again", int'(half_full), 1);
    for (int i = 0; i < D / 2 + 1; i++) step(0, '0, 1, 0);
    step(0, '0, 0, 0);
    chk_flags("R3 empty after half test");

    // R7 / R8 rewind replay
    do_reset();
    for (int i = 0; i < 10; i++) step(1, pat(i + 300), 0, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0);
    step(0, '0, 0, 0);
    step(1, 9'h0FF, 1, 1);
    chk_flags("R8 after rewind");
    check(empty == 0, "R7 replay pending", int'(empty), 0);
    for (int i = 0; i < 10; i++) step(0, '0, 1, 0);
    step(0, '0, 0, 0);
    chk_flags("R7 replay drained");

    // R4 / R10 / R8 at full
    do_reset();
    for (int i = 0; i < D; i++) step(1, pat(i + 700), 0, 0);
    chk_flags("R4 full");
    check(full == 1, "R4 full set", int'(full), 1);
    step(1, 9'h155, 0, 0);
    chk_flags("R4 write while full");
    step(1, 9'h0AA, 1, 0);
    chk_flags("R10 full r+w");
    check(full == 0, "R10 read accepted", int'(full), 0);
    step(0, '0, 0, 1);
    chk_flags("R8 rewind to full");
    check(full == 1, "R8 full after rewind", int'(full), 1);
    for (int i = 0; i < D; i++) step(0, '0, 1, 0);
    step(0, '0, 0, 0);
    chk_flags("R4 drained");
    step(0, '0, 0, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule